// File: doc/BRIEF.md
# Masked Acceptance Filter Router

This block decides, for every received frame identifier, whether the frame is kept and which of two receive buffers should store it. It holds a bank of filter pairs. Each pair has a mask word, a match word and an enable bit. A frame identifier is checked against all enabled pairs in parallel. The result is registered and appears on the cycle after the lookup strobe.

A partition value sets the split between the two buffers. Filters whose index is at or below the partition steer hits into buffer 0. Filters above it steer hits into buffer 1. The reserved partition value 31 switches buffer 1 off, and every accepted frame then goes to buffer 0. When several filters hit, the lowest-numbered one wins, and its index is reported with the result.

Software programs the masks, match words, enables and partition through a single-cycle write port. Identifiers are 29 bits wide. An 11-bit standard identifier can be presented with a flag, and the block then places it in the top 11 bits of the compare field.

Top module: `acc_filter_router`

## Requirements
- R1: After synchronous reset, all result outputs are 0, every filter is disabled and the partition is 31, so no lookup is accepted until a filter is enabled.
- R2: An enabled filter `k` hits when `(id & mask[k]) == (match[k] & mask[k])`. A lookup is accepted if any enabled filter hits.
- R3: A filter whose enable bit is 0 never hits, whatever its mask and match contents.
- R4: When no enabled filter hits, `res_accept`, `res_buf_sel` and `res_index` are all 0, while `res_valid` still reports the lookup.
- R5: When several filters hit, `res_index` is the lowest hitting index, and that filter decides the routing.
- R6: With partition equal to 31, every accepted frame has `res_buf_sel` = 0, whatever filter index hit.
- R7: With partition `p` < 31, a hit on filter `k` gives `res_buf_sel` = 0 when `k <= p` and `res_buf_sel` = 1 when `k > p`.
- R8: With `rx_std` = 1, the compare identifier is `{rx_id[10:0], 18'b0}` and `rx_id[28:11]` is ignored. With `rx_std` = 0, all 29 bits of `rx_id` are used.
- R9: A lookup with `rx_valid` high produces its result with `res_valid` = 1 exactly one clock later. In a cycle that follows no lookup, `res_valid` and `res_accept` are 0.
- R10: Write port: `wr_sel` 0 writes mask[`wr_index`], 1 writes match[`wr_index`], 2 writes enable[`wr_index`] from `wr_data[0]`, and 3 writes the partition from `wr_data[4:0]` (`wr_index` is ignored). A lookup in the same cycle as a write uses the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 match, 2 enable, 3 partition |
| wr_index | input | 5 | Filter number for the write |
| wr_data | input | 29 | Write data |
| rx_valid | input | 1 | Lookup strobe |
| rx_std | input | 1 | 1: identifier is an 11-bit standard one in rx_id[10:0] |
| rx_id | input | 29 | Received identifier |
| res_valid | output | 1 | Result present (one cycle after rx_valid) |
| res_accept | output | 1 | Some enabled filter hit |
| res_buf_sel | output | 1 | 0: first buffer, 1: second buffer |
| res_index | output | 5 | Index of the winning filter |

## Verification
Every result is due on the first rising edge after the lookup strobe. The bench drives a lookup at a falling edge, removes the strobe at the next falling edge and reads all four result outputs at that moment, half a cycle after the register captured them. Register writes become visible to lookups one edge after they are presented, and the same-cycle write-and-lookup case is read at that same point to show the old contents were used. Idle cycles are sampled in the same way to confirm that `res_valid` drops.

// File: rtl/afr_pkg.sv
package afr_pkg;

  // Targets of the register write port
  typedef enum logic [1:0] {
    WR_MASK  = 2'd0,
    WR_MATCH = 2'd1,
    WR_EN    = 2'd2,
    WR_PART  = 2'd3
  } afr_wr_sel_e;

endpackage

// File: rtl/afr_filter_bank.sv
module afr_filter_bank
  import afr_pkg::*;
#(
  parameter int NUM_FLT = 32,
  parameter int ID_W    = 29,
  localparam int IDX_W  = $clog2(NUM_FLT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  afr_wr_sel_e        wr_sel,
  input  logic [IDX_W-1:0]   wr_index,
  input  logic [ID_W-1:0]    wr_data,
  input  logic [ID_W-1:0]    cmp_id,
  output logic [NUM_FLT-1:0] hit_vec,
  output logic [NUM_FLT-1:0] en_vec
);

  for (genvar k = 0; k < NUM_FLT; k++) begin : g_flt
    logic [ID_W-1:0] mask_q;
    logic [ID_W-1:0] match_q;
    logic            en_q;
    logic            sel_this;

    assign sel_this = wr_en && (wr_index == IDX_W'(k));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q  <= '0;
        match_q <= '0;
        en_q    <= 1'b0;
      end else if (sel_this) begin
        case (wr_sel)
          WR_MASK:  mask_q  <= wr_data;
          WR_MATCH: match_q <= wr_data;
          WR_EN:    en_q    <= wr_data[0];
          default:  ;
        endcase
      end
    end

    assign hit_vec[k] = en_q && ((cmp_id & mask_q) == (match_q & mask_q));
    assign en_vec[k]  = en_q;
  end

endmodule

// File: rtl/afr_prio_enc.sv
module afr_prio_enc #(
  parameter int NUM_FLT = 32,
  localparam int IDX_W  = $clog2(NUM_FLT)
) (
  input  logic [NUM_FLT-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);

  always_comb begin
    win_idx = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/afr_route.sv
module afr_route
  import afr_pkg::*;
#(
  parameter int NUM_FLT  = 32,
  parameter int PART_W   = 5,
  parameter int PART_OFF = 31,
  parameter int ID_W     = 29,
  localparam int IDX_W   = $clog2(NUM_FLT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  afr_wr_sel_e       wr_sel,
  input  logic [ID_W-1:0]   wr_data,
  input  logic              any_hit,
  input  logic [IDX_W-1:0]  win_idx,
  output logic              buf_sel,
  output logic [PART_W-1:0] part_cur
);

  logic [PART_W-1:0] part_q;

  always_ff @(posedge clk) begin
    if (rst) part_q <= PART_W'(PART_OFF);
    else if (wr_en && wr_sel == WR_PART) part_q <= wr_data[PART_W-1:0];
  end

  logic second_on;
  assign second_on = (part_q != PART_W'(PART_OFF));
  assign buf_sel   = any_hit && second_on && (int'(win_idx) > int'(part_q));
  assign part_cur  = part_q;

endmodule

// File: rtl/acc_filter_router.sv
module acc_filter_router
  import afr_pkg::*;
#(
  parameter int NUM_FLT  = 32,
  parameter int ID_W     = 29,
  parameter int STD_W    = 11,
  parameter int PART_W   = 5,
  parameter int PART_OFF = 31,
  localparam int IDX_W   = $clog2(NUM_FLT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [ID_W-1:0]  wr_data,
  input  logic             rx_valid,
  input  logic             rx_std,
  input  logic [ID_W-1:0]  rx_id,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_buf_sel,
  output logic [IDX_W-1:0] res_index
);

  afr_wr_sel_e       wsel;
  logic [ID_W-1:0]   cmp_id;
  logic [NUM_FLT-1:0] hit_vec;
  logic [NUM_FLT-1:0] en_vec;
  logic              any_hit;
  logic [IDX_W-1:0]  win_idx;
  logic              buf_sel;
  logic [PART_W-1:0] part_cur;

  assign wsel = afr_wr_sel_e'(wr_sel);

  // Standard identifiers sit in the top bits of the compare field
  assign cmp_id = rx_std ? {rx_id[STD_W-1:0], {(ID_W-STD_W){1'b0}}} : rx_id;

  afr_filter_bank #(.NUM_FLT(NUM_FLT), .ID_W(ID_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wsel), .wr_index(wr_index),
    .wr_data(wr_data), .cmp_id(cmp_id), .hit_vec(hit_vec), .en_vec(en_vec)
  );

  afr_prio_enc #(.NUM_FLT(NUM_FLT)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  afr_route #(.NUM_FLT(NUM_FLT), .PART_W(PART_W), .PART_OFF(PART_OFF), .ID_W(ID_W)) u_route (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wsel), .wr_data(wr_data),
    .any_hit(any_hit), .win_idx(win_idx), .buf_sel(buf_sel), .part_cur(part_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_accept  <= 1'b0;
      res_buf_sel <= 1'b0;
      res_index   <= '0;
    end else begin
      res_valid   <= rx_valid;
      res_accept  <= rx_valid && any_hit;
      res_buf_sel <= rx_valid && buf_sel;
      res_index   <= (rx_valid && any_hit) ? win_idx : '0;
    end
  end

endmodule

// File: rtl/afr_checker.sv
module afr_checker #(
  parameter int NUM_FLT  = 32,
  parameter int PART_W   = 5,
  parameter int PART_OFF = 31,
  localparam int IDX_W   = $clog2(NUM_FLT)
) (
  input logic               clk,
  input logic               rst,
  input logic               rx_valid,
  input logic               res_valid,
  input logic               res_accept,
  input logic               res_buf_sel,
  input logic [IDX_W-1:0]   res_index,
  input logic [PART_W-1:0]  part_cur,
  input logic [NUM_FLT-1:0] en_vec
);

  logic               past_ok;
  logic               rxv_d;
  logic [PART_W-1:0]  part_d;
  logic [NUM_FLT-1:0] en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      rxv_d   <= 1'b0;
      part_d  <= PART_W'(PART_OFF);
      en_d    <= '0;
    end else begin
      past_ok <= 1'b1;
      rxv_d   <= rx_valid;
      part_d  <= part_cur;
      en_d    <= en_vec;
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (res_valid == rxv_d));

  assert_accept_valid_R9: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> res_valid);

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !res_accept |-> (!res_buf_sel && res_index == '0));

  assert_hit_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_accept) |-> en_d[res_index]);

  assert_second_off_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_accept && part_d == PART_W'(PART_OFF)) |-> !res_buf_sel);

  assert_split_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && res_accept && part_d != PART_W'(PART_OFF))
      |-> (res_buf_sel == (int'(res_index) > int'(part_d))));

endmodule

bind acc_filter_router afr_checker #(
  .NUM_FLT(NUM_FLT), .PART_W(PART_W), .PART_OFF(PART_OFF)
) chk_i (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .res_valid(res_valid),
  .res_accept(res_accept), .res_buf_sel(res_buf_sel), .res_index(res_index),
  .part_cur(part_cur), .en_vec(en_vec)
);

// File: tb/acc_filter_router_tb.sv
module acc_filter_router_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [4:0]  wr_index = '0;
  logic [28:0] wr_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_std = 1'b0;
  logic [28:0] rx_id = '0;
  logic        res_valid, res_accept, res_buf_sel;
  logic [4:0]  res_index;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_filter_router dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_index(wr_index),
    .wr_data(wr_data), .rx_valid(rx_valid), .rx_std(rx_std), .rx_id(rx_id),
    .res_valid(res_valid), .res_accept(res_accept), .res_buf_sel(res_buf_sel),
    .res_index(res_index)
  );

  // Table, partition = 10: std flag, id, expected accept, buffer, index
  localparam int NV = 10;
  localparam logic        V_STD [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 0};
  localparam logic [28:0] V_ID  [NV] = '{29'h0ABCDE12, 29'h0A000001, 29'h00000555,
                                          29'h00000123, 29'h00000124, 29'h000002A5,
                                          29'h000002A5, 29'h1FFFFAA5, 29'h0ABCDE03,
                                          29'h1F000003};
  localparam logic        V_ACC [NV] = '{1, 1, 1, 1, 0, 1, 0, 1, 1, 1};
  localparam logic        V_BUF [NV] = '{0, 1, 0, 1, 0, 0, 0, 0, 0, 1};
  localparam logic [4:0]  V_IDX [NV] = '{2, 20, 5, 31, 0, 7, 0, 7, 2, 31};
  localparam string       V_REQ [NV] = '{"R5", "R7", "R2", "R3", "R4", "R8",
                                          "R8", "R8", "R5", "R7"};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int idx, input logic [28:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_index = 5'(idx); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setf(input int idx, input logic [28:0] m, input logic [28:0] v, input bit en);
    wr(0, idx, m);
    wr(1, idx, v);
    wr(2, idx, 29'(en));
  endtask

  // Drive one lookup; the result is read one edge later
  task automatic look(input string req, input logic std, input logic [28:0] id,
                      input bit acc, input bit bsel, input int idx);
    @(negedge clk);
    rx_valid = 1'b1; rx_std = std; rx_id = id;
    @(negedge clk);
    rx_valid = 1'b0;
    check("R9", {req, " valid"}, int'(res_valid), 1);
    check(req, "accept", int'(res_accept), int'(acc));
    check(req, "buf_sel", int'(res_buf_sel), int'(bsel));
    check(req, "index", int'(res_index), idx);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "valid", int'(res_valid), 0);
    check("R1", "accept", int'(res_accept), 0);
    check("R1", "index", int'(res_index), 0);
    look("R1", 0, 29'h0, 0, 0, 0);

    // R9: idle cycle after a lookup
    @(negedge clk);
    check("R9", "idle valid", int'(res_valid), 0);
    check("R9", "idle accept", int'(res_accept), 0);

    // Filter setup
    setf(0,  29'h1FFFFFFF, 29'h00000123, 0);
    setf(2,  29'h1FFFFF00, 29'h0ABCDE00, 1);
    setf(5,  29'h1FFFFFFF, 29'h00000555, 1);
    setf(7,  29'h1FFC0000, {11'h2A5, 18'h0}, 1);
    setf(20, 29'h1F000000, 29'h0A000000, 1);
    setf(31, 29'h0000000F, 29'h00000003, 1);

    // R6: partition still 31 after reset
    look("R6", 0, 29'h0A000001, 1, 0, 20);
    look("R6", 0, 29'h00000123, 1, 0, 31);

    wr(3, 0, 29'd10);
    for (int i = 0; i < NV; i++)
      look(V_REQ[i], V_STD[i], V_ID[i], V_ACC[i], V_BUF[i], V_IDX[i]);

    // R7: boundaries of the split
    wr(3, 0, 29'd30);
    look("R7", 0, 29'h00000123, 1, 1, 31);
    wr(3, 0, 29'd20);
    look("R7", 0, 29'h0A000001, 1, 0, 20);
    wr(3, 7, 29'h1FFFFFF3);   // R10: only low 5 bits used -> 19
    look("R10", 0, 29'h0A000001, 1, 1, 20);
    wr(3, 0, 29'd1);
    look("R7", 0, 29'h0ABCDE12, 1, 1, 2);

    // R10: write and lookup in the same cycle use the old contents
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_index = 5'd5; wr_data = 29'd0;
    rx_valid = 1'b1; rx_std = 1'b0; rx_id = 29'h00000555;
    @(negedge clk);
    wr_en = 1'b0; rx_valid = 1'b0;
    check("R10", "same-cycle accept", int'(res_accept), 1);
    check("R10", "same-cycle index", int'(res_index), 5);
    look("R3", 0, 29'h00000555, 0, 0, 0);

    // R3: re-enable filter 0, then its match word hits ahead of filter 31
    wr(2, 0, 29'd1);
    look("R5", 0, 29'h00000123, 1, 0, 0);

    finish_run();
  end

endmodule